// File: doc/BRIEF.md
# UART Interrupt Identification Encoder

This block takes the separate interrupt sources of a 16550-style serial port and merges them into one registered interrupt request and an identification byte that host software reads to find out which source needs service. The sources are line errors, a receive character timeout, received data (compared against the receive FIFO trigger level when the FIFOs are on), an empty transmit holding register, and modem-status changes. Each source is gated by its bit in a four-bit interrupt-enable register held inside the block.

The block also owns the transmit-empty pending flag, because that flag is changed by host accesses that only this block sees. Reading the identification byte while it reports transmit-empty drops the flag. Writing the enable register so that the transmit-empty enable changes re-arms it from the holding-register state. The surrounding UART reports holding-register events through two strobes and supplies every other condition as a level.

Top module: `uart_irq_encoder`

## Requirements
- R1: After reset the identification byte is 0x01, the interrupt request is low, the enable register reads 0 and the transmit-empty pending flag is clear.
- R2: When enable bit 2 is set and any bit of `lsr_err` is set, the low nibble of the identification byte is 0x6, whatever the other sources show.
- R3: When enable bit 0 is set and `rx_timeout` is high, the low nibble is 0xC unless R2 applies; with enable bit 0 clear the timeout is ignored.
- R4: With `fifo_en` high, received data (enable bit 0) gives low nibble 0x4 only when `data_ready` is high and `rx_count` is at or above `rx_trig`; it ranks below R2 and R3.
- R5: With `fifo_en` low, `data_ready` with enable bit 0 is enough for low nibble 0x4, whatever the count.
- R6: Transmit-empty pending with enable bit 1 gives low nibble 0x2, below received data; any bit of `msr_delta` with enable bit 3 gives 0x0, the lowest level; with no active source the low nibble is 0x1.
- R7: An identification read (`iid_rd`) while the registered byte shows 0x2 clears the transmit-empty pending flag; a read showing any other code leaves it unchanged.
- R8: An enable write whose bit 1 differs from the held bit 1 sets pending when the new bit is 1 and `thr_empty` is high, and clears it otherwise; a write that keeps bit 1 leaves pending unchanged.
- R9: An enable write keeps only bits 3:0 of `ier_wdata`; the held value is visible on `ier`.
- R10: Bits 7:6 of the identification byte are 11 when `fifo_en` is high and 00 when low; bits 5:4 are always 0.
- R11: The interrupt request is high exactly when the low nibble of the identification byte is not 0x1, and both change on the same clock edge.
- R12: `thr_load` (holding register written) clears pending with the highest precedence; `thr_drain` (holding register emptied) sets it with the lowest precedence, below R8 and R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| iid_rd | input | 1 | Identification-byte read strobe |
| thr_load | input | 1 | Host wrote the transmit holding register |
| thr_drain | input | 1 | Transmit holding register became empty |
| thr_empty | input | 1 | Transmit holding register is empty (level) |
| lsr_err | input | 4 | Overrun, parity, framing and break flags |
| data_ready | input | 1 | Receive data present |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| rx_timeout | input | 1 | Character-timeout pending |
| msr_delta | input | 4 | Modem-status change flags |
| fifo_en | input | 1 | FIFOs enabled |
| ier | output | 4 | Held interrupt-enable nibble |
| iid | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Every result of this block is due at the first rising edge after the stimulus: the enable register, the pending flag and the identification byte with its request all load on that edge, and the priority is formed from the next-state enable and pending values so an enable write or read side effect shows up without a second cycle of lag. The bench therefore applies inputs just after one edge, predicts the byte, request and enable value from its own model of the requirements, and samples one time unit after the next edge. Strobes are cleared after each sampled edge, so each stimulus affects exactly one edge, and the random phase mixes strobe collisions so the precedence among load, enable write, read and drain is exercised.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // identification low-nibble codes; values are visible to host software
  localparam logic [3:0] CODE_NONE = 4'h1;
  localparam logic [3:0] CODE_LINE = 4'h6;
  localparam logic [3:0] CODE_TMO  = 4'hC;
  localparam logic [3:0] CODE_RXD  = 4'h4;
  localparam logic [3:0] CODE_THR  = 4'h2;
  localparam logic [3:0] CODE_MDM  = 4'h0;

  // enable-nibble bit positions
  localparam int EN_RXD  = 0;
  localparam int EN_THR  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  typedef struct packed {
    logic line;
    logic tmo;
    logic rxd;
    logic thr;
    logic mdm;
  } irq_src_t;

  // received-data condition: level compare only applies with FIFOs on
  function automatic logic rx_level_met(input logic fifo_on, input logic dr,
                                        input logic [7:0] cnt, input logic [7:0] trig);
    return dr && (!fifo_on || (cnt >= trig));
  endfunction

  // fixed priority, highest first
  function automatic logic [3:0] pick_code(input irq_src_t s);
    if (s.line)     return CODE_LINE;
    else if (s.tmo) return CODE_TMO;
    else if (s.rxd) return CODE_RXD;
    else if (s.thr) return CODE_THR;
    else if (s.mdm) return CODE_MDM;
    return CODE_NONE;
  endfunction

  function automatic logic [1:0] fifo_tag(input logic fifo_on);
    return fifo_on ? 2'b11 : 2'b00;
  endfunction

endpackage

// File: rtl/uart_irq_ier_ctl.sv
module uart_irq_ier_ctl
  import uart_irq_pkg::*;
#(
  parameter int EN_W   = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ier_wr,
  input  logic [DATA_W-1:0] ier_wdata,
  input  logic              iid_rd,
  input  logic [3:0]        iid_code_q,
  input  logic              thr_load,
  input  logic              thr_drain,
  input  logic              thr_empty,
  output logic [EN_W-1:0]   ier_q,
  output logic [EN_W-1:0]   ier_nxt,
  output logic              thr_pend_q,
  output logic              thr_pend_nxt,
  output logic              thr_en_toggle,
  output logic              thr_rd_clear
);

  assign ier_nxt       = ier_wr ? ier_wdata[EN_W-1:0] : ier_q;
  assign thr_en_toggle = ier_wr && (ier_wdata[EN_THR] != ier_q[EN_THR]);
  assign thr_rd_clear  = iid_rd && (iid_code_q == CODE_THR);

  always_comb begin
    thr_pend_nxt = thr_pend_q;
    if (thr_load)
      thr_pend_nxt = 1'b0;
    else if (thr_en_toggle)
      thr_pend_nxt = ier_wdata[EN_THR] && thr_empty;
    else if (thr_rd_clear)
      thr_pend_nxt = 1'b0;
    else if (thr_drain)
      thr_pend_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q      <= '0;
      thr_pend_q <= 1'b0;
    end else begin
      ier_q      <= ier_nxt;
      thr_pend_q <= thr_pend_nxt;
    end
  end

endmodule

// File: rtl/uart_irq_src_gate.sv
module uart_irq_src_gate
  import uart_irq_pkg::*;
#(
  parameter int EN_W  = 4,
  parameter int CNT_W = 5,
  parameter int ERR_W = 4,
  parameter int MDM_W = 4
) (
  input  logic [EN_W-1:0]  ier_nxt,
  input  logic             thr_pend_nxt,
  input  logic [ERR_W-1:0] lsr_err,
  input  logic             data_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             rx_timeout,
  input  logic [MDM_W-1:0] msr_delta,
  input  logic             fifo_en,
  output irq_src_t         src
);

  localparam int CMP_W = 8;
  logic [CMP_W-1:0] cnt_ext, trig_ext;

  generate
    if (CNT_W < CMP_W) begin : g_pad
      assign cnt_ext  = {{(CMP_W-CNT_W){1'b0}}, rx_count};
      assign trig_ext = {{(CMP_W-CNT_W){1'b0}}, rx_trig};
    end else begin : g_trunc
      assign cnt_ext  = rx_count[CMP_W-1:0];
      assign trig_ext = rx_trig[CMP_W-1:0];
    end
  endgenerate

  always_comb begin
    src.line = ier_nxt[EN_LINE] && (|lsr_err);
    src.tmo  = ier_nxt[EN_RXD]  && rx_timeout;
    src.rxd  = ier_nxt[EN_RXD]  && rx_level_met(fifo_en, data_ready, cnt_ext, trig_ext);
    src.thr  = ier_nxt[EN_THR]  && thr_pend_nxt;
    src.mdm  = ier_nxt[EN_MDM]  && (|msr_delta);
  end

endmodule

// File: rtl/uart_irq_id_reg.sv
module uart_irq_id_reg
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  irq_src_t   src,
  input  logic       fifo_en,
  output logic [7:0] iid_q,
  output logic       irq_q
);

  logic [3:0] code_nxt;
  logic       req_nxt;

  assign code_nxt = pick_code(src);
  assign req_nxt  = (src != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iid_q <= {4'h0, CODE_NONE};
      irq_q <= 1'b0;
    end else begin
      iid_q <= {fifo_tag(fifo_en), 2'b00, code_nxt};
      irq_q <= req_nxt;
    end
  end

endmodule

// File: rtl/uart_irq_encoder.sv
module uart_irq_encoder
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  input  logic             iid_rd,
  input  logic             thr_load,
  input  logic             thr_drain,
  input  logic             thr_empty,
  input  logic [3:0]       lsr_err,
  input  logic             data_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             rx_timeout,
  input  logic [3:0]       msr_delta,
  input  logic             fifo_en,
  output logic [3:0]       ier,
  output logic [7:0]       iid,
  output logic             irq
);

  localparam int EN_W = 4;

  logic [EN_W-1:0] ier_q, ier_nxt;
  logic            thr_pend, thr_pend_nxt;
  logic            thr_en_toggle, thr_rd_clear;
  irq_src_t        src;
  logic [7:0]      iid_q;
  logic            irq_q;

  uart_irq_ier_ctl #(.EN_W(EN_W), .DATA_W(8)) u_ier (
    .clk          (clk),
    .rst_n        (rst_n),
    .ier_wr       (ier_wr),
    .ier_wdata    (ier_wdata),
    .iid_rd       (iid_rd),
    .iid_code_q   (iid_q[3:0]),
    .thr_load     (thr_load),
    .thr_drain    (thr_drain),
    .thr_empty    (thr_empty),
    .ier_q        (ier_q),
    .ier_nxt      (ier_nxt),
    .thr_pend_q   (thr_pend),
    .thr_pend_nxt (thr_pend_nxt),
    .thr_en_toggle(thr_en_toggle),
    .thr_rd_clear (thr_rd_clear)
  );

  uart_irq_src_gate #(.EN_W(EN_W), .CNT_W(CNT_W), .ERR_W(4), .MDM_W(4)) u_gate (
    .ier_nxt     (ier_nxt),
    .thr_pend_nxt(thr_pend_nxt),
    .lsr_err     (lsr_err),
    .data_ready  (data_ready),
    .rx_count    (rx_count),
    .rx_trig     (rx_trig),
    .rx_timeout  (rx_timeout),
    .msr_delta   (msr_delta),
    .fifo_en     (fifo_en),
    .src         (src)
  );

  uart_irq_id_reg u_id (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (src),
    .fifo_en(fifo_en),
    .iid_q  (iid_q),
    .irq_q  (irq_q)
  );

  assign ier = ier_q;
  assign iid = iid_q;
  assign irq = irq_q;

endmodule

// File: rtl/uart_irq_encoder_sva.sv
module uart_irq_encoder_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       ier_wr,
  input logic [7:0] ier_wdata,
  input logic       iid_rd,
  input logic       thr_load,
  input logic       thr_drain,
  input logic [3:0] lsr_err,
  input logic       fifo_en,
  input logic [3:0] ier,
  input logic [7:0] iid,
  input logic       irq,
  input logic       thr_pend
);

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (iid == 8'h01) && !irq && (ier == 4'h0)) // R1
    else $error("reset state wrong");

  AST_LINE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && (|lsr_err) && !ier_wr) |=> (iid[3:0] == 4'h6)) // R2
    else $error("line status not top priority");

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_rd && (iid[3:0] == 4'h2) && !ier_wr && !thr_drain) |=> !thr_pend) // R7
    else $error("identification read did not clear pending");

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    thr_load |=> !thr_pend) // R12
    else $error("holding write did not clear pending");

  AST_IER_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> (ier == $past(ier_wdata[3:0]))) // R9
    else $error("enable nibble not kept");

  AST_FIFO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (iid[7:4] == {{2{$past(fifo_en)}}, 2'b00})) // R10
    else $error("identification top bits wrong");

  AST_IRQ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iid[3:0] != 4'h1)) // R11
    else $error("request does not match code");

endmodule

bind uart_irq_encoder uart_irq_encoder_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .ier_wr   (ier_wr),
  .ier_wdata(ier_wdata),
  .iid_rd   (iid_rd),
  .thr_load (thr_load),
  .thr_drain(thr_drain),
  .lsr_err  (lsr_err),
  .fifo_en  (fifo_en),
  .ier      (ier),
  .iid      (iid),
  .irq      (irq),
  .thr_pend (thr_pend)
);

// File: tb/tb_uart_irq_encoder.sv
`timescale 1ns/1ps
module tb_uart_irq_encoder;

  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ier_wr = 0, iid_rd = 0, thr_load = 0, thr_drain = 0, thr_empty = 1;
  logic [7:0]    ier_wdata = 0;
  logic [3:0]    lsr_err = 0, msr_delta = 0;
  logic          data_ready = 0, rx_timeout = 0, fifo_en = 0;
  logic [CW-1:0] rx_count = 0, rx_trig = 1;
  logic [3:0]    ier;
  logic [7:0]    iid;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  logic [3:0] m_ier = 0;
  logic       m_thr = 0;
  logic [7:0] m_iid = 8'h01;

  always #4 clk = ~clk;

  uart_irq_encoder dut (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata), .iid_rd(iid_rd),
    .thr_load(thr_load), .thr_drain(thr_drain), .thr_empty(thr_empty), .lsr_err(lsr_err),
    .data_ready(data_ready), .rx_count(rx_count), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .msr_delta(msr_delta), .fifo_en(fifo_en), .ier(ier), .iid(iid), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  // expected low nibble, written as a ranked list of conditions
  function automatic logic [3:0] exp_code(input logic [3:0] en, input logic thr);
    logic rx_ok;
    rx_ok = data_ready && (fifo_en ? (rx_count >= rx_trig) : 1'b1);
    if (en[2] && lsr_err != 0)  return 4'h6;
    if (en[0] && rx_timeout)    return 4'hC;
    if (en[0] && rx_ok)         return 4'h4;
    if (en[1] && thr)           return 4'h2;
    if (en[3] && msr_delta != 0) return 4'h0;
    return 4'h1;
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'h6: return "R2";
      4'hC: return "R3";
      4'h4: return fifo_en ? "R4" : "R5";
      4'h2: return "R6";
      4'h0: return "R6";
      default: return "R11";
    endcase
  endfunction

  // one edge: predict, clock, sample, clear strobes
  task automatic tick();
    logic [3:0] n_ier;
    logic       n_thr;
    logic [3:0] c;
    n_ier = ier_wr ? ier_wdata[3:0] : m_ier;
    if (thr_load)                                    n_thr = 1'b0;
    else if (ier_wr && (ier_wdata[1] != m_ier[1]))   n_thr = ier_wdata[1] && thr_empty;
    else if (iid_rd && m_iid[3:0] == 4'h2)           n_thr = 1'b0;
    else if (thr_drain)                              n_thr = 1'b1;
    else                                             n_thr = m_thr;
    c = exp_code(n_ier, n_thr);
    @(posedge clk); #1;
    m_ier = n_ier; m_thr = n_thr;
    m_iid = {fifo_en ? 2'b11 : 2'b00, 2'b00, c};
    chk(tag_of(c), iid, m_iid);
    chk("R11", {7'b0, irq}, {7'b0, (c != 4'h1)});
    chk("R9", {4'b0, ier}, {4'b0, m_ier});
    ier_wr = 0; iid_rd = 0; thr_load = 0; thr_drain = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", iid, 8'h01);
    chk("R1", {7'b0, irq}, 8'h00);
    chk("R1", {4'b0, ier}, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #1;

    ier_wr = 1; ier_wdata = 8'hFF; tick();
    chk("R9", {4'b0, ier}, 8'h0F);
    chk("R8", iid, 8'h02);
    iid_rd = 1; tick();
    chk("R7", iid, 8'h01);
    ier_wr = 1; ier_wdata = 8'h0F; tick();
    chk("R8", iid, 8'h01);
    thr_drain = 1; tick();
    chk("R12", iid, 8'h02);
    thr_load = 1; tick();
    chk("R12", iid, 8'h01);
    msr_delta = 4'h2; tick();
    chk("R6", iid, 8'h00);
    chk("R6", {7'b0, irq}, 8'h01);
    data_ready = 1; tick();
    chk("R5", iid, 8'h04);
    fifo_en = 1; rx_count = 3; rx_trig = 4; tick();
    chk("R4", iid, 8'hC0);
    rx_count = 4; tick();
    chk("R4", iid, 8'hC4);
    chk("R10", iid & 8'hF0, 8'hC0);
    rx_timeout = 1; tick();
    chk("R3", iid, 8'hCC);
    ier_wr = 1; ier_wdata = 8'h0E; tick();
    chk("R3", iid, 8'hC0);
    lsr_err = 4'h1; tick();
    chk("R2", iid, 8'hC6);
    thr_drain = 1; tick();
    chk("R2", iid, 8'hC6);
    iid_rd = 1; tick();
    lsr_err = 4'h0; tick();
    chk("R7", iid, 8'hC2);
    ier_wr = 1; ier_wdata = 8'hF0; tick();
    chk("R8", iid, 8'hC1);
    chk("R11", {7'b0, irq}, 8'h00);
    fifo_en = 0; tick();
    chk("R10", iid, 8'h01);

    // random phase with fixed seed
    void'($urandom(32'h5EED));
    for (int i = 0; i < 3000; i++) begin
      ier_wr     = ($urandom % 6) == 0;
      ier_wdata  = 8'($urandom);
      iid_rd     = ($urandom % 3) == 0;
      thr_load   = ($urandom % 8) == 0;
      thr_drain  = ($urandom % 5) == 0;
      thr_empty  = 1'($urandom);
      lsr_err    = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
      msr_delta  = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
      data_ready = 1'($urandom);
      rx_timeout = ($urandom % 5) == 0;
      fifo_en    = ($urandom % 4) != 0;
      rx_count   = CW'($urandom % 17);
      case ($urandom % 4)
        0: rx_trig = 1;
        1: rx_trig = 4;
        2: rx_trig = 8;
        default: rx_trig = 14;
      endcase
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule